// File: doc/BRIEF.md
# Looping Table Streamer with Counter Substitution

The block plays a fixed byte table out without end. It starts at entry 0, steps one entry per accepted byte and goes back to entry 0 after the last entry. Each byte is offered to a downstream byte-wide serializer with a valid/ready handshake. The table lives in a read-only memory that is filled when the design is built, and nothing changes it at run time.

A few table positions, called slots, send a live counter instead of the stored byte. Each slot has its own parameter for the table address it replaces, its count direction and its reset value. Each slot counter moves by one every time the whole table has been sent, so a receiver can count passes from inside the stream. An enable input lets the stream be paused without losing its position.

Top module: `table_streamer`

## Requirements
- R1: A synchronous active-high reset drives `valid_o` low and returns the read position to entry 0, so the first byte offered after reset is entry 0.
- R2: Away from slot addresses, the byte offered for entry i equals ((i*37 + floor(i/32)) XOR 0x5A) mod 256, and entries come out in ascending order.
- R3: The entry that follows entry DEPTH-1 is entry 0, with no gap and no missing entry.
- R4: At a slot's table address the offered byte is that slot's counter value for the current pass, not the stored byte.
- R5: Each slot counter starts at its configured reset value and changes by one at the clock edge that transfers entry DEPTH-1. Up slots add one and down slots subtract one. At no other time does it change.
- R6: Slot counters wrap modulo 256 (0xFF+1 gives 0x00, and 0x00-1 gives 0xFF).
- R7: While `valid_o` is high and `ready_i` is low, `data_o` and the read position hold. A transfer is a clock edge where `valid_o` and `ready_i` are both high.
- R8: `valid_o` equals the value `enable_i` had at the previous clock edge. While `valid_o` is low, the read position and the counters hold.
- R9: With `enable_i` and `ready_i` held high, one byte is transferred on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable_i | input | 1 | Stream enable; low pauses the stream |
| ready_i | input | 1 | Serializer can take the offered byte |
| data_o | output | W | Offered byte (table entry or slot counter) |
| valid_o | output | 1 | `data_o` carries a byte to transfer |

## Verification
Two things can happen at the same clock edge: the table wrapping from its last entry to entry 0, and a counter slot being presented. The bench puts one slot at entry 0 and another at entry DEPTH-1. At entry 0, the byte on the wire must already hold the stepped count. At entry DEPTH-1, the byte is the old count, and it must stay unchanged while ready is held low in front of it, until the transfer that steps it. The slot reset values sit next to 0x00 and 0xFF, so both counters wrap within a few passes. A behavioural model compares every clock cycle under random ready and enable gaps.

// File: rtl/tss_pkg.sv
package tss_pkg;

  // Build-time table contents: entry i of the read-only table.
  function automatic int unsigned tss_fill(int unsigned idx);
    return ((idx * 32'd37) + (idx >> 5)) ^ 32'h5A;
  endfunction

endpackage

// File: rtl/tss_rom.sv
module tss_rom #(
  parameter int unsigned DEPTH = 4000,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      mem[i] = W'(tss_pkg::tss_fill(i));
    end
  end

  // Registered read only, so the memory maps onto block RAM.
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tss_addr_seq.sv
module tss_addr_seq #(
  parameter int unsigned DEPTH = 4000,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] addr_cur,
  output logic          wrap
);

  logic [AW-1:0] addr_inc;

  always_comb begin
    addr_inc = (addr_q == LAST) ? '0 : addr_q + AW'(1);
    addr_cur = take ? addr_inc : addr_q;
    wrap     = take && (addr_q == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_cur;
  end

endmodule

// File: rtl/tss_slot_ctr.sv
module tss_slot_ctr #(
  parameter int unsigned W       = 8,
  parameter bit          UP      = 1'b1,
  parameter logic [W-1:0] INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= INIT;
    end else if (step) begin
      if (UP) cnt <= cnt + W'(1);
      else    cnt <= cnt - W'(1);
    end
  end

endmodule

// File: rtl/table_streamer.sv
module table_streamer #(
  parameter int unsigned DEPTH     = 4000,
  parameter int unsigned W         = 8,
  parameter int unsigned NUM_SLOTS = 2,
  parameter logic [NUM_SLOTS-1:0][31:0] SLOT_ADDR = {32'd2000, 32'd0},
  parameter logic [NUM_SLOTS-1:0]       SLOT_UP   = 2'b01,
  parameter logic [NUM_SLOTS-1:0][W-1:0] SLOT_INIT = {8'hFF, 8'h00}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable_i,
  input  logic         ready_i,
  output logic [W-1:0] data_o,
  output logic         valid_o
);

  localparam int unsigned AW = $clog2(DEPTH);

  logic          valid_q;
  logic          take;
  logic          wrap;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_cur;
  logic [W-1:0]  rom_q;
  logic [NUM_SLOTS-1:0]        hit_c;
  logic [NUM_SLOTS-1:0]        hit_q;
  logic [NUM_SLOTS-1:0][W-1:0] cnt;

  assign take    = valid_q && ready_i;
  assign valid_o = valid_q;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= enable_i;
  end

  tss_addr_seq #(.DEPTH(DEPTH)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .addr_q   (addr_q),
    .addr_cur (addr_cur),
    .wrap     (wrap)
  );

  // The read address already points at the next entry on a transfer edge,
  // so rom_q always holds the entry for addr_q.
  tss_rom #(.DEPTH(DEPTH), .W(W)) u_rom (
    .clk   (clk),
    .raddr (addr_cur),
    .rdata (rom_q)
  );

  for (genvar s = 0; s < int'(NUM_SLOTS); s++) begin : g_slot
    assign hit_c[s] = (addr_cur == AW'(SLOT_ADDR[s]));

    tss_slot_ctr #(
      .W    (W),
      .UP   (SLOT_UP[s]),
      .INIT (SLOT_INIT[s])
    ) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .step (wrap),
      .cnt  (cnt[s])
    );
  end

  // Slot matches are registered next to the memory output register.
  always_ff @(posedge clk) begin
    if (rst) hit_q <= '0;
    else     hit_q <= hit_c;
  end

  // Lowest slot index wins if two slots share an address.
  always_comb begin
    data_o = rom_q;
    for (int s = int'(NUM_SLOTS) - 1; s >= 0; s--) begin
      if (hit_q[s]) data_o = cnt[s];
    end
  end

endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
  parameter int unsigned AW = 12,
  parameter int unsigned W  = 8,
  parameter int unsigned NS = 2,
  parameter int unsigned LAST = 3999
) (
  input logic          clk,
  input logic          rst,
  input logic          enable_i,
  input logic          ready_i,
  input logic          valid_o,
  input logic [W-1:0]  data_o,
  input logic [AW-1:0] addr_q,
  input logic [NS*W-1:0] cnt
);

  // R7: an offered byte holds until it is taken
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i && enable_i) |=> (valid_o && $stable(data_o) && $stable(addr_q)));

  // R8: valid tracks enable one edge later
  assert_valid_en_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (valid_o == $past(enable_i)));

  // R8: no movement while nothing is offered
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !valid_o |=> $stable(addr_q));

  // R3: last entry is followed by entry 0
  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ready_i && addr_q == AW'(LAST)) |=> (addr_q == '0));

  // R5: counters move only on the transfer of the last entry
  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && ready_i && addr_q == AW'(LAST)) |=> $stable(cnt));

  // R9: a transfer always advances the position
  assert_advance_R9: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ready_i && addr_q != AW'(LAST)) |=> (addr_q == $past(addr_q) + AW'(1)));

endmodule

bind table_streamer tss_checker #(
  .AW   ($clog2(DEPTH)),
  .W    (W),
  .NS   (NUM_SLOTS),
  .LAST (DEPTH - 1)
) u_tss_chk (
  .clk      (clk),
  .rst      (rst),
  .enable_i (enable_i),
  .ready_i  (ready_i),
  .valid_o  (valid_o),
  .data_o   (data_o),
  .addr_q   (addr_q),
  .cnt      (cnt)
);

// File: tb/test_table_streamer.sv
module test_table_streamer;

  localparam int DEPTH = 4000;
  localparam int W     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable_i = 1'b0;
  logic ready_i  = 1'b0;
  logic [W-1:0] data_o;
  logic valid_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  // slot 0 at entry 0 counts up from 0xFE; slot 1 at last entry counts down from 0x01
  table_streamer #(
    .DEPTH     (DEPTH),
    .W         (W),
    .NUM_SLOTS (2),
    .SLOT_ADDR ({32'(DEPTH - 1), 32'd0}),
    .SLOT_UP   (2'b01),
    .SLOT_INIT ({8'h01, 8'hFE})
  ) i_table_streamer (
    .clk      (clk),
    .rst      (rst),
    .enable_i (enable_i),
    .ready_i  (ready_i),
    .data_o   (data_o),
    .valid_o  (valid_o)
  );

  // ---------------- reference model ----------------
  int m_addr   = 0;
  int m_valid  = 0;
  int m_up     = 'hFE;
  int m_dn     = 'h01;
  int m_passes = 0;
  int prev_take_hold = 0;
  int prev_data = 0;
  bit seen_up_wrap = 0;
  bit seen_dn_wrap = 0;

  function automatic int entry(int i);
    return ((i * 37 + i / 32) ^ 'h5A) & 'hFF;
  endfunction

  function automatic int expect_byte(int a);
    if (a == 0)         return m_up;
    if (a == DEPTH - 1) return m_dn;
    return entry(a);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_addr = 0; m_valid = 0; m_up = 'hFE; m_dn = 'h01; m_passes = 0;
    end else begin
      if (m_valid != 0 && ready_i) begin
        if (m_addr == DEPTH - 1) begin
          m_addr = 0;
          m_up = (m_up + 1) & 'hFF;
          m_dn = (m_dn - 1) & 'hFF;
          m_passes++;
        end else begin
          m_addr++;
        end
      end
      m_valid = enable_i ? 1 : 0;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h addr=%0d", req, act, exp, m_addr);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(valid_o == (m_valid != 0), "R8", int'(valid_o), m_valid);
      if (valid_o && m_valid != 0) begin
        if (m_addr == 0 || m_addr == DEPTH - 1)
          check(int'(data_o) == expect_byte(m_addr), "R4", int'(data_o), expect_byte(m_addr));
        else if (m_addr == 1 && m_passes > 0)
          check(int'(data_o) == entry(1), "R3", int'(data_o), entry(1));
        else
          check(int'(data_o) == entry(m_addr), "R2", int'(data_o), entry(m_addr));
        if (prev_take_hold != 0)
          check(int'(data_o) == prev_data, "R7", int'(data_o), prev_data);
        if (m_addr == 0 && m_passes >= 2 && data_o == 8'h00) seen_up_wrap = 1;
        if (m_addr == DEPTH - 1 && m_passes >= 1 && data_o == 8'hFF) seen_dn_wrap = 1;
      end
      prev_take_hold = (valid_o && !ready_i && enable_i) ? 1 : 0;
      prev_data = int'(data_o);
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int takes;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(valid_o == 1'b0, "R1", int'(valid_o), 0);
    rst = 1'b0;
    enable_i = 1'b1;
    ready_i  = 1'b1;
    @(negedge clk);
    // R1: first offered byte is entry 0 (slot 0 initial value)
    check(valid_o && data_o == 8'hFE, "R1", int'(data_o), 'hFE);

    // R9: full pass with ready and enable held high
    takes = 0;
    for (int c = 0; c < DEPTH; c++) begin
      if (valid_o && ready_i) takes++;
      @(negedge clk);
    end
    check(takes == DEPTH, "R9", takes, DEPTH);

    // random ready and enable gaps, with a long stall at the last entry
    for (int c = 0; c < 26000; c++) begin
      ready_i  = ($urandom_range(0, 9) < 7);
      enable_i = ($urandom_range(0, 49) != 0);
      if (m_addr == DEPTH - 1 && valid_o && (c % 3 == 0)) begin
        ready_i = 1'b0;
        enable_i = 1'b1;
        repeat (5) @(negedge clk);
      end
      @(negedge clk);
    end

    // enable low: position and counters must hold (R8)
    enable_i = 1'b0;
    ready_i  = 1'b1;
    repeat (20) @(negedge clk);
    check(valid_o == 1'b0, "R8", int'(valid_o), 0);
    enable_i = 1'b1;
    repeat (200) @(negedge clk);

    check(m_passes >= 3, "R5", m_passes, 3);
    check(seen_up_wrap, "R6", int'(seen_up_wrap), 1);
    check(seen_dn_wrap, "R6", int'(seen_dn_wrap), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule